// File: doc/BRIEF.md
# Single-Cycle Load/ALU/Store Datapath

This block is the execution core of a very small programmable processor. It holds a register file, a data memory and an ALU. Each clock cycle, a set of control inputs chooses one operation. A load copies a memory word into a register. An ALU operation combines one or two registers and writes the result to a register. A store copies a register into a memory word. Any unit that can present one operation per cycle, such as a controller or a test harness, drives the inputs. The block does not fetch or sequence instructions.

Memory data reaches the ALU only through the register file. Work such as adding two memory words and writing the sum back to memory therefore takes a sequence of operations: load, load, ALU, store.

A separate preload port writes memory words directly, so that a harness can place data before a program runs. Two combinational observation ports expose any register and any memory word.

Top module: `ldst_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets every register to zero. Reset leaves data memory unchanged. While `rst` is high, no operation writes memory, but the preload port still does.
- R2: `op_kind` = 2'b00 is idle. It changes no register. If the preload port is also inactive, it changes no memory word.
- R3: `op_kind` = 2'b01 is a load. At the next rising edge, the register at `rd_addr` takes the memory word at `mem_addr`. Memory is unchanged.
- R4: `op_kind` = 2'b10 is an ALU operation. The register at `rd_addr` takes f(reg[`src_a`], reg[`src_b`]). The function code `alu_fn` selects f: 2'b00 gives a+b, 2'b01 gives a-b, 2'b10 gives bitwise AND, 2'b11 gives bitwise OR. Results wrap modulo 2^DATA_W.
- R5: `op_kind` = 2'b11 is a store. The memory word at `mem_addr` takes reg[`src_a`]. The register file is unchanged.
- R6: At most one memory write happens per cycle. If `pre_we` is high, it writes `pre_data` to `pre_addr`. A store in the same cycle is dropped, whichever address it names.
- R7: Every operation reads its operands from the state held before the edge. An ALU operation whose destination is also a source uses the old value, so r = r + r doubles r.
- R8: `obs_reg_data` shows the register at `obs_reg_addr`, and `obs_mem_data` shows the memory word at `obs_mem_addr`. Both are combinational, with no cycle of latency.
- R9: Take memory word 0 = 99 and word 1 = 102. The sequence load r0←word 0, load r1←word 1, r2 = r0 + r1, store r2→word 9 leaves 201 in word 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the register file |
| op_kind | input | 2 | Operation select: idle, load, ALU, store |
| rd_addr | input | RA_W | Destination register for load and ALU |
| src_a | input | RA_W | First source register (ALU operand a, store source) |
| src_b | input | RA_W | Second source register (ALU operand b) |
| mem_addr | input | MA_W | Memory word for load or store |
| alu_fn | input | 2 | ALU function code |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | MA_W | Preload word address |
| pre_data | input | DATA_W | Preload data |
| obs_reg_addr | input | RA_W | Register observation address |
| obs_reg_data | output | DATA_W | Register observation data |
| obs_mem_addr | input | MA_W | Memory observation address |
| obs_mem_data | output | DATA_W | Memory observation data |

## Verification
The bench builds the block with its default parameters: 16 registers of 16 bits and 256 memory words. At that size, every memory word can be preloaded, loaded and stored, and every pairing of source registers can be tried with each of the four ALU functions.

Directed cases cover three things. One is wrap at both ends of the adder and subtractor. Another is an operation whose destination is also its source. The last is a store that meets a preload in the same cycle. All expected values come from a bench-side model of the register file and memory.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [1:0] {
    OPK_IDLE  = 2'b00,
    OPK_LOAD  = 2'b01,
    OPK_ALU   = 2'b10,
    OPK_STORE = 2'b11
  } opkind_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } alufn_e;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DATA_W = 16,
  parameter int NREGS  = 16,
  localparam int RA_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RA_W-1:0]   ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [RA_W-1:0]   rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic [RA_W-1:0]   ro_addr,
  output logic [DATA_W-1:0] ro_data
);

  logic [DATA_W-1:0] regs [NREGS];

  // one flop group per register, each with its own write decode
  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == RA_W'(gi));
    always_ff @(posedge clk) begin
      if (rst)      regs[gi] <= '0;
      else if (hit) regs[gi] <= wdata;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
  assign ro_data = regs[ro_addr];

endmodule

// File: rtl/dp_datamem.sv
module dp_datamem #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 256,
  localparam int MA_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MA_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [MA_W-1:0]   obs_addr,
  output logic [DATA_W-1:0] obs_data
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_data  = mem[rd_addr];
  assign obs_data = mem[obs_addr];

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        fn,
  output logic [DATA_W-1:0] y
);

  function automatic logic [DATA_W-1:0] alu_eval(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] z,
    input alufn_e            f
  );
    logic [DATA_W-1:0] r;
    case (f)
      FN_ADD:  r = x + z;
      FN_SUB:  r = x - z;
      FN_AND:  r = x & z;
      default: r = x | z;
    endcase
    return r;
  endfunction

  assign y = alu_eval(a, b, alufn_e'(fn));

endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import dp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NREGS     = 16,
  parameter int MEM_WORDS = 256,
  localparam int RA_W     = $clog2(NREGS),
  localparam int MA_W     = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_kind,
  input  logic [RA_W-1:0]   rd_addr,
  input  logic [RA_W-1:0]   src_a,
  input  logic [RA_W-1:0]   src_b,
  input  logic [MA_W-1:0]   mem_addr,
  input  logic [1:0]        alu_fn,
  input  logic              pre_we,
  input  logic [MA_W-1:0]   pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  input  logic [RA_W-1:0]   obs_reg_addr,
  output logic [DATA_W-1:0] obs_reg_data,
  input  logic [MA_W-1:0]   obs_mem_addr,
  output logic [DATA_W-1:0] obs_mem_data
);

  opkind_e opk;
  assign opk = opkind_e'(op_kind);

  // decoded operation events, named for the checker
  logic do_load, do_alu, do_store;
  assign do_load  = !rst && (opk == OPK_LOAD);
  assign do_alu   = !rst && (opk == OPK_ALU);
  assign do_store = !rst && (opk == OPK_STORE) && !pre_we;

  logic [DATA_W-1:0] rf_a, rf_b, alu_y, mem_rdata;

  logic              rf_we;
  logic [RA_W-1:0]   rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  assign rf_we    = do_load || do_alu;
  assign rf_waddr = rd_addr;
  assign rf_wdata = do_load ? mem_rdata : alu_y;

  // single memory write port shared by preload and store
  logic              mem_we;
  logic [MA_W-1:0]   mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  assign mem_we    = pre_we || do_store;
  assign mem_waddr = pre_we ? pre_addr : mem_addr;
  assign mem_wdata = pre_we ? pre_data : rf_a;

  dp_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .ra_addr (src_a),
    .ra_data (rf_a),
    .rb_addr (src_b),
    .rb_data (rf_b),
    .ro_addr (obs_reg_addr),
    .ro_data (obs_reg_data)
  );

  dp_datamem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk      (clk),
    .we       (mem_we),
    .waddr    (mem_waddr),
    .wdata    (mem_wdata),
    .rd_addr  (mem_addr),
    .rd_data  (mem_rdata),
    .obs_addr (obs_mem_addr),
    .obs_data (obs_mem_data)
  );

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .a  (rf_a),
    .b  (rf_b),
    .fn (alu_fn),
    .y  (alu_y)
  );

endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int DATA_W = 16,
  parameter int RA_W   = 4,
  parameter int MA_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        op_kind,
  input logic [RA_W-1:0]   rd_addr,
  input logic [MA_W-1:0]   mem_addr,
  input logic              pre_we,
  input logic [MA_W-1:0]   pre_addr,
  input logic [DATA_W-1:0] pre_data,
  input logic              rf_we,
  input logic [RA_W-1:0]   rf_waddr,
  input logic [DATA_W-1:0] rf_wdata,
  input logic [DATA_W-1:0] rf_a,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              mem_we,
  input logic [MA_W-1:0]   mem_waddr,
  input logic [DATA_W-1:0] mem_wdata
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op_kind == 2'b00) |-> (!rf_we && (mem_we == pre_we))); // R2

  AST_LOAD_PATH: assert property (@(posedge clk) disable iff (rst)
    (op_kind == 2'b01) |-> (rf_we && rf_waddr == rd_addr && rf_wdata == mem_rdata)); // R3

  AST_ALU_WRITES: assert property (@(posedge clk) disable iff (rst)
    (op_kind == 2'b10) |-> (rf_we && rf_waddr == rd_addr && (mem_we == pre_we))); // R4

  AST_STORE_PATH: assert property (@(posedge clk) disable iff (rst)
    (op_kind == 2'b11 && !pre_we) |-> (!rf_we && mem_we && mem_waddr == mem_addr && mem_wdata == rf_a)); // R5

  AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    pre_we |-> (mem_we && mem_waddr == pre_addr && mem_wdata == pre_data)); // R6

endmodule

bind ldst_datapath dp_checker #(.DATA_W(DATA_W), .RA_W(RA_W), .MA_W(MA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_kind   (op_kind),
  .rd_addr   (rd_addr),
  .mem_addr  (mem_addr),
  .pre_we    (pre_we),
  .pre_addr  (pre_addr),
  .pre_data  (pre_data),
  .rf_we     (rf_we),
  .rf_waddr  (rf_waddr),
  .rf_wdata  (rf_wdata),
  .rf_a      (rf_a),
  .mem_rdata (mem_rdata),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr),
  .mem_wdata (mem_wdata)
);

// File: tb/ldst_datapath_bench.sv
module ldst_datapath_bench;

  localparam int DW = 16;
  localparam int NR = 16;
  localparam int NW = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    op_kind = 2'b00;
  logic [3:0]    rd_addr = '0, src_a = '0, src_b = '0;
  logic [7:0]    mem_addr = '0;
  logic [1:0]    alu_fn = '0;
  logic          pre_we = 1'b0;
  logic [7:0]    pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  logic [3:0]    obs_reg_addr = '0;
  logic [DW-1:0] obs_reg_data;
  logic [7:0]    obs_mem_addr = '0;
  logic [DW-1:0] obs_mem_data;

  always #5 clk = ~clk;

  ldst_datapath u_ldst_datapath (
    .clk(clk), .rst(rst), .op_kind(op_kind), .rd_addr(rd_addr),
    .src_a(src_a), .src_b(src_b), .mem_addr(mem_addr), .alu_fn(alu_fn),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .obs_reg_addr(obs_reg_addr), .obs_reg_data(obs_reg_data),
    .obs_mem_addr(obs_mem_addr), .obs_mem_data(obs_mem_data)
  );

  logic [DW-1:0] m_rf  [NR];
  logic [DW-1:0] m_mem [NW];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek_reg(input int r, output logic [DW-1:0] v);
    obs_reg_addr = 4'(r); #1; v = obs_reg_data;
  endtask

  task automatic peek_mem(input int a, output logic [DW-1:0] v);
    obs_mem_addr = 8'(a); #1; v = obs_mem_data;
  endtask

  task automatic check_all_regs(input string req);
    logic [DW-1:0] v;
    for (int r = 0; r < NR; r++) begin
      peek_reg(r, v); chk(req, v, m_rf[r]);
    end
  endtask

  // bench-side ALU, written with integer arithmetic
  function automatic logic [DW-1:0] ref_alu(input int a, input int b, input int f);
    int r;
    case (f)
      0: r = (a + b) % 65536;
      1: r = (a - b + 65536) % 65536;
      2: r = a & b;
      default: r = a | b;
    endcase
    return DW'(r);
  endfunction

  task automatic preload(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = 8'(a); pre_data = d;
    @(posedge clk); #1;
    pre_we = 1'b0;
    m_mem[a] = d;
  endtask

  // one operation; model updated from pre-edge state
  task automatic apply_op(input int k, input int rd, input int a, input int b,
                          input int ma, input int f);
    logic [DW-1:0] va, vb;
    va = m_rf[a]; vb = m_rf[b];
    @(negedge clk);
    op_kind = 2'(k); rd_addr = 4'(rd); src_a = 4'(a); src_b = 4'(b);
    mem_addr = 8'(ma); alu_fn = 2'(f);
    @(posedge clk); #1;
    op_kind = 2'b00;
    case (k)
      1: m_rf[rd] = m_mem[ma];
      2: m_rf[rd] = ref_alu(int'(va), int'(vb), f);
      3: m_mem[ma] = va;
      default: ;
    endcase
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, keep;
    // R1: reset clears registers
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int r = 0; r < NR; r++) m_rf[r] = '0;
    check_all_regs("R1 reset");

    // preload every word, observe every word (R8)
    for (int a = 0; a < NW; a++) preload(a, DW'(a * 517 + 16'h1234));
    for (int a = 0; a < NW; a++) begin
      peek_mem(a, v); chk("R8 mem observe", v, m_mem[a]);
    end

    // R2: idle cycles with noisy selects change nothing
    for (int i = 0; i < 8; i++) apply_op(0, i, i + 1, i + 2, i * 9, i % 4);
    check_all_regs("R2 idle regs");
    for (int i = 0; i < 8; i++) begin
      peek_mem(i * 9, v); chk("R2 idle mem", v, m_mem[i * 9]);
    end

    // R3: loads into every register
    for (int r = 0; r < NR; r++) begin
      apply_op(1, r, 0, 0, (r * 17 + 3) % NW, 0);
      peek_reg(r, v); chk("R3 load", v, m_rf[r]);
      peek_mem((r * 17 + 3) % NW, v); chk("R3 mem untouched", v, m_mem[(r * 17 + 3) % NW]);
    end

    // R4: all functions over all source pairs
    for (int f = 0; f < 4; f++)
      for (int a = 0; a < NR; a++)
        for (int b = 0; b < NR; b++) begin
          apply_op(2, (a + 3 * b + f) % NR, a, b, 0, f);
          peek_reg((a + 3 * b + f) % NR, v);
          chk("R4 alu", v, m_rf[(a + 3 * b + f) % NR]);
        end

    // R4: wrap corners
    preload(20, 16'h0000); preload(21, 16'h0001); preload(22, 16'hFFFF);
    apply_op(1, 4, 0, 0, 20, 0);
    apply_op(1, 5, 0, 0, 21, 0);
    apply_op(1, 6, 0, 0, 22, 0);
    apply_op(2, 7, 4, 5, 0, 1);
    peek_reg(7, v); chk("R4 sub wrap", v, 16'hFFFF);
    apply_op(2, 8, 6, 5, 0, 0);
    peek_reg(8, v); chk("R4 add wrap", v, 16'h0000);

    // R7: destination equals both sources
    apply_op(1, 3, 0, 0, 40, 0);
    keep = m_rf[3];
    apply_op(2, 3, 3, 3, 0, 0);
    peek_reg(3, v); chk("R7 self add", v, DW'(keep * 2));

    // R5: stores to every word
    for (int a = 0; a < NW; a++) begin
      apply_op(3, 0, (a * 5) % NR, 0, a, 0);
      peek_mem(a, v); chk("R5 store", v, m_mem[a]);
    end
    check_all_regs("R5 regs untouched");

    // R6: preload collides with store
    @(negedge clk);
    op_kind = 2'b11; src_a = 4'd2; mem_addr = 8'd7;
    pre_we = 1'b1; pre_addr = 8'd7; pre_data = 16'hBEEF;
    @(posedge clk); #1;
    op_kind = 2'b00; pre_we = 1'b0; m_mem[7] = 16'hBEEF;
    peek_mem(7, v); chk("R6 same addr", v, 16'hBEEF);
    @(negedge clk);
    op_kind = 2'b11; src_a = 4'd2; mem_addr = 8'd9;
    pre_we = 1'b1; pre_addr = 8'd8; pre_data = 16'h5A5A;
    @(posedge clk); #1;
    op_kind = 2'b00; pre_we = 1'b0; m_mem[8] = 16'h5A5A;
    peek_mem(8, v); chk("R6 preload lands", v, 16'h5A5A);
    peek_mem(9, v); chk("R6 store dropped", v, m_mem[9]);

    // R1: reset mid-run with a store requested
    @(negedge clk);
    rst = 1'b1; op_kind = 2'b11; src_a = 4'd7; mem_addr = 8'd5;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0; op_kind = 2'b00;
    for (int r = 0; r < NR; r++) m_rf[r] = '0;
    check_all_regs("R1 mid reset");
    peek_mem(5, v); chk("R1 mem kept", v, m_mem[5]);

    // R9: worked example
    preload(0, 16'd99); preload(1, 16'd102);
    apply_op(1, 0, 0, 0, 0, 0);
    apply_op(1, 1, 0, 0, 1, 0);
    apply_op(2, 2, 0, 1, 0, 0);
    apply_op(3, 0, 2, 0, 9, 0);
    peek_mem(9, v); chk("R9 sum word", v, 16'd201);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule